// File: doc/BRIEF.md
# Double-Buffered 8-Bit PWM Timer

This block is an 8-bit pulse-width modulation timer. An up-counter advances on a clock-enable tick. The tick comes from a free-running prescaler on the main clock or from an external slow-clock pulse. The output comes from a toggle flip-flop. The flip-flop inverts when the count matches the active duty value, and inverts again when the count wraps from 255 to 0. The output pin always drives the inverse of that flip-flop. The wrap also raises a single-cycle interrupt pulse.

The duty value is double-buffered. While the timer runs, a write lands in a holding register and moves into the active compare register only at the next wrap. While the timer is stopped, a write takes effect at once. Reads always return the active value. While stopped, software can preset the flip-flop level, which selects the pulse polarity. The pin keeps whatever level it had when the timer stopped.

Top module: `pwm8_timer`

## Requirements
- R1: After reset, `pwm_out` is 1 (flip-flop cleared to 0), `rd_data` is 0 and `irq` is 0.
- R2: While `run_en` is 1 the counter gains one on each tick. While `run_en` is 0 it is held at 0, so after a restart with a tick on every cycle the first `irq` is seen exactly 256 cycles later.
- R3: On a tick where the count equals the active compare value, the flip-flop inverts. With compare value C, the flip-flop spends C+1 ticks at its post-wrap level and 255-C ticks inverted. When C is 255, the match and the wrap cancel and no pulse appears.
- R4: On a tick where the count is 255, the count returns to 0, the flip-flop inverts, and `irq` is 1 for exactly the next cycle.
- R5: `pwm_out` is the logical inverse of the timer flip-flop at all times.
- R6: While stopped, `ff_load` sets the flip-flop to `ff_init` on the next edge. While running, `ff_load` has no effect.
- R7: A write while running changes the holding register only. `rd_data` keeps the previous active value until the wrap, and then shows the written value.
- R8: A write while stopped appears on `rd_data` on the next cycle.
- R9: A write in the same cycle as a wrap loads that cycle's write data into the active register.
- R10: While stopped with no `ff_load`, `pwm_out` keeps its level.
- R11: When `slow_mode` is 0, `src_sel` codes 0, 1, 2 and 3 tick every 2048, 128, 32 and 8 main clocks. Code 4 ticks on every clock, code 5 ticks on each `sub_tick` pulse, and codes 6 and 7 never tick.
- R12: When `slow_mode` is 1, code 3 ticks on every eighth `sub_tick` pulse, code 5 ticks on each `sub_tick` pulse, and every other code never ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 = timer running, 0 = stopped |
| src_sel | input | 3 | Tick source code |
| slow_mode | input | 1 | Restricts the sources to the slow-clock ones |
| sub_tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Duty register write strobe |
| wr_data | input | 8 | Duty write data |
| rd_data | output | 8 | Active compare value |
| ff_init | input | 1 | Level preset into the flip-flop |
| ff_load | input | 1 | Preset strobe, honoured only while stopped |
| pwm_out | output | 1 | Inverse of the timer flip-flop |
| irq | output | 1 | One-cycle pulse after each wrap |

## Verification
The bench drives a duty write in exactly the cycle of a wrap. A design that let the stale holding value win there would show the old duty on `rd_data` for a whole period. It runs compare values of 0 and 255. An off-by-one in the match would shift the pulse edge by a tick, and a design that did not cancel the coincident toggles at 255 would flip the polarity every period. It issues presets while running, which a careless design would let flip the pin mid-period. It times the intervals between wraps for several prescaler taps and for the slow-clock sources, which exposes a miswired tap or a missing low-speed restriction. It restarts from stop to confirm that the count was cleared and did not carry over.

// File: rtl/pwm8_pkg.sv
// Package: source-select codes shared by the tick generator, the checker
// and anything that drives src_sel.
package pwm8_pkg;
    localparam int SRC_W = 3;
    localparam logic [SRC_W-1:0] SRC_TAP_A = 3'd0;  // main clock / 2^TAP_A
    localparam logic [SRC_W-1:0] SRC_TAP_B = 3'd1;
    localparam logic [SRC_W-1:0] SRC_TAP_C = 3'd2;
    localparam logic [SRC_W-1:0] SRC_TAP_D = 3'd3;  // also sub/8 in slow mode
    localparam logic [SRC_W-1:0] SRC_MAIN  = 3'd4;  // every main clock
    localparam logic [SRC_W-1:0] SRC_SUB   = 3'd5;  // every sub_tick pulse
    localparam int NUM_TAPS = 4;
endpackage

// File: rtl/pwm8_tick_gen.sv
// Tick generator: a free-running main-clock prescaler with four power-of-two
// taps, plus a small prescaler on the slow-clock pulse. It picks one tick
// enable from src_sel; the slow mode restricts the choice to the slow-clock
// sources. Assumes sub_tick is a one-cycle pulse synchronous to clk.
module pwm8_tick_gen
    import pwm8_pkg::*;
#(
    parameter int TAP_A = 11,
    parameter int TAP_B = 7,
    parameter int TAP_C = 5,
    parameter int TAP_D = 3,
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             slow_mode,
    input  logic             sub_tick,
    output logic             tick
);
    localparam int PRE_W = TAP_A;

    logic [PRE_W-1:0]    pre_q;
    logic [SUB_W-1:0]    sub_q;
    logic [NUM_TAPS-1:0] tap_tick;
    logic                sub_div_tick;

    // Free-running main-clock prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Slow-clock pulse prescaler, advanced by each sub_tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        sub_q <= '0;
        else if (sub_tick) sub_q <= sub_q + 1'b1;
    end

    // One tap per division ratio: fires when the low bits are all ones.
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int K = (i == 0) ? TAP_A : (i == 1) ? TAP_B :
                           (i == 2) ? TAP_C : TAP_D;
        assign tap_tick[i] = &pre_q[K-1:0];
    end

    assign sub_div_tick = sub_tick && (&sub_q);

    // Source multiplexer.
    always_comb begin
        tick = 1'b0;
        if (slow_mode) begin
            if (src_sel == SRC_TAP_D)    tick = sub_div_tick;
            else if (src_sel == SRC_SUB) tick = sub_tick;
        end else begin
            case (src_sel)
                SRC_TAP_A: tick = tap_tick[0];
                SRC_TAP_B: tick = tap_tick[1];
                SRC_TAP_C: tick = tap_tick[2];
                SRC_TAP_D: tick = tap_tick[3];
                SRC_MAIN:  tick = 1'b1;
                SRC_SUB:   tick = sub_tick;
                default:   tick = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pwm8_duty_buf.sv
// Duty buffer: a holding register and an active compare register. While
// running, writes go to the holding stage and move to the active stage at
// the wrap. While stopped, writes go straight through. A write in the wrap
// cycle wins over the held value. Assumes ovf is only asserted while running.
module pwm8_duty_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ovf,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act_q
);
    logic [W-1:0] hold_q;

    // Holding stage captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    // Active stage: immediate load when stopped, wrap-time load when running.
    always_ff @(posedge clk) begin
        if (!rst_n)              act_q <= '0;
        else if (!run && wr_en)  act_q <= wr_data;
        else if (ovf)            act_q <= wr_en ? wr_data : hold_q;
    end
endmodule

// File: rtl/pwm8_core.sv
// Counter core: an up-counter that advances on tick while running and is
// held at zero while stopped, a toggle flip-flop inverted on match and on
// wrap, and the one-cycle interrupt pulse. Assumes cmp is stable between
// wraps while running.
module pwm8_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    input  logic         ff_init,
    input  logic         ff_load,
    output logic [W-1:0] cnt_q,
    output logic         ff_q,
    output logic         ovf,
    output logic         irq_q
);
    logic match;

    assign ovf   = run && tick && (cnt_q == {W{1'b1}});
    assign match = run && tick && (cnt_q == cmp);

    // Counter: clear while stopped, advance on tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // Toggle flip-flop: preset only when stopped, toggle on match xor wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)               ff_q <= 1'b0;
        else if (!run) begin
            if (ff_load)          ff_q <= ff_init;
        end else if (match ^ ovf) ff_q <= ~ff_q;
    end

    // Interrupt pulse follows the wrap by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf;
    end
endmodule

// File: rtl/pwm8_timer.sv
// Top: double-buffered PWM timer. Ties together the tick generator, the
// duty buffer and the counter core, and drives the pin as the inverse of
// the timer flip-flop. Synchronous active-low reset throughout.
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int TAP_A  = 11,
    parameter int TAP_B  = 7,
    parameter int TAP_C  = 5,
    parameter int TAP_D  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              slow_mode,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    input  logic              ff_init,
    input  logic              ff_load,
    output logic              pwm_out,
    output logic              irq
);
    logic              tick;
    logic              ovf;
    logic              tff;
    logic [DUTY_W-1:0] cnt_q;
    logic [DUTY_W-1:0] act_cmp;

    pwm8_tick_gen #(
        .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D), .SUB_W(TAP_D)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .slow_mode(slow_mode),
        .sub_tick(sub_tick), .tick(tick)
    );

    pwm8_duty_buf #(.W(DUTY_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .run(run_en), .ovf(ovf),
        .wr_en(wr_en), .wr_data(wr_data), .act_q(act_cmp)
    );

    pwm8_core #(.W(DUTY_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick), .cmp(act_cmp),
        .ff_init(ff_init), .ff_load(ff_load), .cnt_q(cnt_q), .ff_q(tff),
        .ovf(ovf), .irq_q(irq)
    );

    assign rd_data = act_cmp;
    assign pwm_out = ~tff;
endmodule

// File: rtl/pwm8_timer_chk.sv
// Checker: temporal properties of the PWM timer, bound to the top module.
module pwm8_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_en,
    input logic [2:0]   src_sel,
    input logic         slow_mode,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic         ff_load,
    input logic         pwm_out,
    input logic         irq,
    input logic [W-1:0] cnt_q,
    input logic         tick,
    input logic         ovf
);
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> cnt_q == '0);
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_q == '0);
    p_rd_held_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !ovf) |=> $stable(rd_data));
    p_stopped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_en) |=> rd_data == $past(wr_data));
    p_wrap_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && wr_en) |=> rd_data == $past(wr_data));
    p_pin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !ff_load) |=> $stable(pwm_out));
    p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_mode && src_sel[2:1] == 2'b11) |-> !tick);
    p_slow_sources_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_mode && src_sel != 3'd3 && src_sel != 3'd5) |-> !tick);
endmodule

bind pwm8_timer pwm8_timer_chk #(.W(DUTY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .slow_mode(slow_mode), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ff_load(ff_load), .pwm_out(pwm_out), .irq(irq), .cnt_q(cnt_q),
    .tick(tick), .ovf(ovf)
);

// File: tb/test_pwm8_timer.sv
// Bench: a requirement-level reference model, directed corner cases and a
// seeded random phase. Inputs change at negedge, outputs are compared there.
module test_pwm8_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] src_sel = 3'd4;
    logic       slow_mode = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ff_init = 1'b0;
    logic       ff_load = 1'b0;
    logic       pwm_out;
    logic       irq;

    int n_chk = 0, n_fail = 0, cyc_n = 0, sub_period = 5;
    bit done = 0;
    string req = "R1";

    // Reference model state.
    logic [10:0] m_pre;
    logic [2:0]  m_sub;
    logic [7:0]  m_cnt, m_act, m_hold;
    logic        m_ff, m_irq;

    always #4 clk = ~clk;   // 125 MHz

    pwm8_timer i_pwm8_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .slow_mode(slow_mode), .sub_tick(sub_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ff_init(ff_init),
        .ff_load(ff_load), .pwm_out(pwm_out), .irq(irq)
    );

    function automatic logic exp_tick(logic [10:0] pre, logic [2:0] sub);
        if (slow_mode) begin
            if (src_sel == 3'd3) return sub_tick && (sub == 3'd7);
            if (src_sel == 3'd5) return sub_tick;
            return 1'b0;
        end
        case (src_sel)
            3'd0: return pre == 11'h7FF;
            3'd1: return pre[6:0] == 7'h7F;
            3'd2: return pre[4:0] == 5'h1F;
            3'd3: return pre[2:0] == 3'h7;
            3'd4: return 1'b1;
            3'd5: return sub_tick;
            default: return 1'b0;
        endcase
    endfunction

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        logic t, ov, mt;
        if (!rst_n) begin
            m_pre = '0; m_sub = '0; m_cnt = '0; m_act = '0; m_hold = '0;
            m_ff = 0; m_irq = 0;
        end else begin
            t  = exp_tick(m_pre, m_sub);
            ov = run_en && t && m_cnt == 8'hFF;
            mt = run_en && t && m_cnt == m_act;
            m_irq = ov;
            if (!run_en) begin
                if (ff_load) m_ff = ff_init;
            end else if (mt ^ ov) m_ff = ~m_ff;
            if (!run_en && wr_en) m_act = wr_data;
            else if (ov) m_act = wr_en ? wr_data : m_hold;
            if (wr_en) m_hold = wr_data;
            if (!run_en) m_cnt = '0; else if (t) m_cnt = m_cnt + 1'b1;
            m_pre = m_pre + 1'b1;
            if (sub_tick) m_sub = m_sub + 1'b1;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    // One clock: wait for negedge, compare against model, drive sub_tick.
    task automatic cyc();
        @(negedge clk);
        cyc_n++;
        if (rst_n) begin
            check({req, " R5 pwm_out"}, {7'd0, pwm_out}, {7'd0, ~m_ff});
            check({req, " rd_data"}, rd_data, m_act);
            check({req, " R4 irq"}, {7'd0, irq}, {7'd0, m_irq});
        end
        sub_tick = (cyc_n % sub_period) == 0;
        wr_en = 0; ff_load = 0;
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    // Cycles from now to the next irq (bounded).
    function automatic int dummy(int x); return x; endfunction
    task automatic gap_to_irq(output int n);
        n = 0;
        do begin cyc(); n++; end while (!irq && n < 20000);
    endtask

    initial begin
        int g;
        logic lvl;
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        req = "R1";
        check("R1 pwm_out after reset", {7'd0, pwm_out}, 8'd1);
        check("R1 rd_data after reset", rd_data, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'd0);
        rst_n = 1;
        cyc();

        req = "R8"; wr(8'h40);
        check("R8 stopped write visible", rd_data, 8'h40);
        req = "R6"; ff_init = 1; ff_load = 1; cyc();
        check("R6 preset while stopped", {7'd0, pwm_out}, 8'd0);

        // R2: restart, first wrap after exactly 256 ticks.
        req = "R2"; run_en = 1; src_sel = 3'd4;
        gap_to_irq(g);
        check("R2 first irq after restart", g[7:0] ^ 8'(g >> 8), 8'h01 ^ 8'h00);
        check("R2 restart cycles", 8'(g == 256), 8'd1);
        req = "R3"; cycles(600);

        // R7: write while running is deferred.
        req = "R7"; wr(8'h80);
        check("R7 rd keeps old value", rd_data, 8'h40);
        gap_to_irq(g);
        check("R7 rd after wrap", rd_data, 8'h80);

        // R6: preset while running ignored.
        req = "R6"; ff_init = ~pwm_out; ff_load = 1; cyc(); cycles(20);

        // R3 corners: compare 0 and 255.
        req = "R3"; wr(8'h00); gap_to_irq(g); cycles(520);
        wr(8'hFF); gap_to_irq(g);
        lvl = pwm_out;
        for (int i = 0; i < 300; i++) begin
            cyc();
            check("R3 no pulse at 255", {7'd0, pwm_out}, {7'd0, lvl});
        end

        // R9: write in the wrap cycle.
        req = "R9"; wr(8'h10);
        gap_to_irq(g);
        while (m_cnt != 8'hFF) cyc();
        wr(8'h33);
        check("R9 wrap-cycle write", rd_data, 8'h33);
        check("R9 irq in same step", {7'd0, irq}, 8'd1);
        cycles(300);

        // R10: stop holds the pin.
        req = "R10"; cycles(37); lvl = pwm_out; run_en = 0;
        for (int i = 0; i < 50; i++) begin
            cyc();
            check("R10 pin held when stopped", {7'd0, pwm_out}, {7'd0, lvl});
        end

        // R11: prescaler taps.
        req = "R11"; wr(8'h05); run_en = 1; src_sel = 3'd3;
        gap_to_irq(g); gap_to_irq(g);
        check("R11 div8 wrap period", 8'(g == 2048), 8'd1);
        src_sel = 3'd2; cycles(1200);
        src_sel = 3'd1; cycles(1500);
        run_en = 0; cyc(); wr(8'h01); run_en = 1;
        src_sel = 3'd0; cycles(4600);
        src_sel = 3'd6; cycles(300); src_sel = 3'd7; cycles(300);
        src_sel = 3'd5; gap_to_irq(g); gap_to_irq(g);
        check("R11 sub_tick wrap period", 8'(g == 256 * sub_period), 8'd1);

        // R12: slow mode.
        req = "R12"; slow_mode = 1; src_sel = 3'd4; cycles(400);
        src_sel = 3'd5; gap_to_irq(g); gap_to_irq(g);
        check("R12 slow sub wrap period", 8'(g == 256 * sub_period), 8'd1);
        src_sel = 3'd3; cycles(3000);
        slow_mode = 0;

        // Random phase.
        req = "R7/R9 random";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) run_en = ~run_en;
            if ($urandom_range(0, 299) == 0) src_sel = ($urandom_range(0, 1) == 0) ? 3'd4 : 3'd3;
            if ($urandom_range(0, 49) == 0) begin
                wr_en = 1;
                case ($urandom_range(0, 3))
                    0: wr_data = 8'h00;
                    1: wr_data = 8'hFF;
                    default: wr_data = 8'($urandom);
                endcase
            end
            if ($urandom_range(0, 99) == 0) begin
                ff_load = 1; ff_init = 1'($urandom);
            end
            cyc();
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc_n);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule